// File: doc/BRIEF.md
# Joint Translation Buffer Command Unit

This block holds the main address-translation buffer that instruction fetch and data access share. It is two-way set associative, and its total entry count is a parameter. The default is 256 entries, and 512 is the other intended size. Software never reaches the entries directly. It loads two descriptor registers and an index register, then writes a command code. The unit can probe the buffer for a virtual page and address-space tag, write an entry with or without discarding the micro-translation buffers, or discard those micro buffers on their own.

Register writes use a valid/ready handshake. While a command is in flight, `reg_wr_ready` is low and every register write waits, whatever its address. Reads are combinational. Each accepted command runs for a fixed two cycles after acceptance and then raises `cmd_done` for one cycle. In that same cycle, `utlb_flush` pulses for any command that must empty the micro buffers. The cycle that shows `cmd_done` already accepts the next write.

Top module: `jtlb_cmd_unit`

## Requirements
- R1: After reset, all four register reads return zero, `reg_wr_ready` is 1, `cmd_done` and `utlb_flush` are 0, and every entry is invalid, so any probe misses.
- R2: The register selects are 0 for descriptor A, 1 for descriptor B, 2 for the index and 3 for the command (the command register reads as zero). A write is taken when `reg_wr_valid` and `reg_wr_ready` are both high. `reg_wr_ready` is low from the cycle after a command is accepted until its completion, so a write presented during that time is held and taken afterwards.
- R3: A command accepted at clock edge E produces `cmd_done` high for exactly the one cycle that follows edge E+2, and low in the two cycles before it.
- R4: The descriptor A layout is virtual page in bits [31:PAGE_SHIFT], valid in bit 9, global in bit 8 and tag in bits [7:0]. The set is the low log2(ENTRIES/2) bits of the virtual page. An entry index is set*2+way. A probe (command code 1) that hits exactly one way writes that index to the index register with bit 31 clear.
- R5: A probe that matches no way writes 0x8000_0000 to the index register (bit 31 is the lookup-error flag).
- R6: A probe that matches both ways of its set writes 0x8000_0001 to the index register.
- R7: A stored entry with its global bit set matches a probe for any tag. An entry without the global bit matches only an equal tag.
- R8: Write (code 2) stores the descriptors at the set and way chosen by the index register's low bits (way = bit 0) and pulses `utlb_flush` with `cmd_done`.
- R9: Write-keep (code 3) stores an entry the same way but leaves `utlb_flush` low.
- R10: Writing an entry with both descriptors zero erases it. An all-zero descriptor A never matches a probe.
- R11: Micro-flush (code 4) pulses `utlb_flush` with `cmd_done`, does not alter the index register or any entry, and works with the lookup-error flag set.
- R12: A command word other than 1 to 4 is ignored. It starts nothing, raises no `cmd_done`, keeps `reg_wr_ready` high and changes no register.
- R13: A probe never changes descriptor A. A single hit loads the matched entry's descriptor B into descriptor B; a miss or a duplicate leaves descriptor B unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_valid | input | 1 | Register write request |
| reg_wr_ready | output | 1 | Write accepted this cycle when high with valid |
| reg_addr | input | 2 | Register select for the write |
| reg_wdata | input | 32 | Write data |
| reg_rd_addr | input | 2 | Register select for the read |
| reg_rdata | output | 32 | Combinational read data |
| cmd_done | output | 1 | One-cycle completion pulse |
| utlb_flush | output | 1 | One-cycle micro-buffer invalidate pulse |

## Verification
Two things can happen in the same cycle: the completion of one command and the acceptance of the next. The bench provokes this by issuing a micro-flush in the exact cycle a probe reports `cmd_done`. It then checks that the probe's index result survives, that the second command keeps its own two-cycle latency, and that its flush pulse arrives. A second overlap is a descriptor write held back by a running probe. The bench judges it by confirming that the probe used the old descriptor and that the held value lands only afterwards.

// File: rtl/jtlb_pkg.sv
`timescale 1ns/1ps
package jtlb_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned GLB_BIT = 8;
  localparam int unsigned VLD_BIT = 9;
  localparam int unsigned ERR_BIT = 31;

  typedef enum logic [1:0] {
    RSEL_PDA = 2'd0,
    RSEL_PDB = 2'd1,
    RSEL_IDX = 2'd2,
    RSEL_CMD = 2'd3
  } rsel_e;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PROBE    = 3'd1,
    OP_WRITE    = 3'd2,
    OP_WRITE_NI = 3'd3,
    OP_UINV     = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  function automatic op_e decode_op(input logic [DATA_W-1:0] w);
    op_e r;
    r = OP_NONE;
    if (w[DATA_W-1:3] == '0) begin
      case (w[2:0])
        3'd1:    r = OP_PROBE;
        3'd2:    r = OP_WRITE;
        3'd3:    r = OP_WRITE_NI;
        3'd4:    r = OP_UINV;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/jtlb_way_store.sv
`timescale 1ns/1ps
module jtlb_way_store #(
  parameter int unsigned SETS   = 128,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [DATA_W-1:0] dat_mem [SETS];

  // valid bits are the only state that needs a reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_set] <= wr_valid;
      if (rd_en) rd_valid <= vld_q[rd_set];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set] <= wr_tag;
      dat_mem[wr_set] <= wr_data;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_set];
      rd_data <= dat_mem[rd_set];
    end
  end
endmodule

// File: rtl/jtlb_match.sv
`timescale 1ns/1ps
module jtlb_match #(
  parameter int unsigned VPN_W  = 19,
  parameter int unsigned ASID_W = 8
) (
  input  logic              ent_valid,
  input  logic              ent_global,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VPN_W-1:0]  key_vpn,
  output logic              hit
);
  logic vpn_eq;
  logic asid_ok;

  always_comb begin
    vpn_eq  = (ent_vpn == key_vpn);
    asid_ok = ent_global || (ent_asid == key_asid);
    hit     = ent_valid && vpn_eq && asid_ok;
  end
endmodule

// File: rtl/jtlb_seq.sv
`timescale 1ns/1ps
module jtlb_seq
  import jtlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  start_op,
  output logic ready,
  output logic in_exec,
  output logic in_fin,
  output op_e  op,
  output logic done,
  output logic flush
);
  st_e st_q;
  op_e op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_NONE;
      done  <= 1'b0;
      flush <= 1'b0;
    end else begin
      done  <= (st_q == ST_FIN);
      flush <= (st_q == ST_FIN) && ((op_q == OP_WRITE) || (op_q == OP_UINV));
      case (st_q)
        ST_IDLE: if (start) begin
          st_q <= ST_EXEC;
          op_q <= start_op;
        end
        ST_EXEC: st_q <= ST_FIN;
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ready   = (st_q == ST_IDLE);
    in_exec = (st_q == ST_EXEC);
    in_fin  = (st_q == ST_FIN);
    op      = op_q;
  end
endmodule

// File: rtl/jtlb_cmd_unit.sv
`timescale 1ns/1ps
module jtlb_cmd_unit
  import jtlb_pkg::*;
#(
  parameter int unsigned ENTRIES    = 256,
  parameter int unsigned PAGE_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_valid,
  output logic        reg_wr_ready,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_rd_addr,
  output logic [31:0] reg_rdata,
  output logic        cmd_done,
  output logic        utlb_flush
);
  localparam int unsigned WAYS  = 2;
  localparam int unsigned SETS  = ENTRIES / WAYS;
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned IDX_W = SET_W + 1;
  localparam int unsigned VPN_W = DATA_W - PAGE_SHIFT;
  localparam int unsigned TAG_W = VPN_W + ASID_W + 1;

  logic [DATA_W-1:0] pda_q, pdb_q, idx_q;
  logic              acc, start;
  op_e               wr_op;
  logic              ready, in_exec, in_fin, done, flush;
  op_e               op;

  logic [VPN_W-1:0]  key_vpn;
  logic [ASID_W-1:0] key_asid;
  logic [SET_W-1:0]  key_set;
  logic [SET_W-1:0]  tgt_set;
  logic              tgt_way;
  logic              is_write;
  logic [TAG_W-1:0]  new_tag;

  logic [WAYS-1:0]   hit;
  logic [DATA_W-1:0] way_data [WAYS];
  logic [DATA_W-1:0] probe_idx;
  logic              single_hit;
  logic [DATA_W-1:0] hit_data;

  always_comb begin
    acc      = reg_wr_valid && reg_wr_ready;
    wr_op    = decode_op(reg_wdata);
    start    = acc && (reg_addr == RSEL_CMD) && (wr_op != OP_NONE);
    key_vpn  = pda_q[DATA_W-1:PAGE_SHIFT];
    key_asid = pda_q[ASID_W-1:0];
    key_set  = pda_q[PAGE_SHIFT +: SET_W];
    tgt_set  = idx_q[IDX_W-1:1];
    tgt_way  = idx_q[0];
    is_write = (op == OP_WRITE) || (op == OP_WRITE_NI);
    new_tag  = {pda_q[GLB_BIT], key_asid, key_vpn};
  end

  jtlb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .start_op (wr_op),
    .ready    (ready),
    .in_exec  (in_exec),
    .in_fin   (in_fin),
    .op       (op),
    .done     (done),
    .flush    (flush)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;

    jtlb_way_store #(
      .SETS   (SETS),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (in_exec && is_write && (tgt_way == 1'(w))),
      .wr_set   (tgt_set),
      .wr_valid (pda_q[VLD_BIT]),
      .wr_tag   (new_tag),
      .wr_data  (pdb_q),
      .rd_en    (in_exec && (op == OP_PROBE)),
      .rd_set   (key_set),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_data  (rd_data)
    );

    jtlb_match #(
      .VPN_W  (VPN_W),
      .ASID_W (ASID_W)
    ) u_match (
      .ent_valid  (rd_valid),
      .ent_global (rd_tag[TAG_W-1]),
      .ent_asid   (rd_tag[VPN_W +: ASID_W]),
      .ent_vpn    (rd_tag[VPN_W-1:0]),
      .key_asid   (key_asid),
      .key_vpn    (key_vpn),
      .hit        (hit[w])
    );

    assign way_data[w] = rd_data;
  end

  // probe outcome: single hit gives {set,way}, otherwise the error forms
  always_comb begin
    probe_idx  = '0;
    single_hit = 1'b0;
    hit_data   = way_data[0];
    case (hit)
      2'b01: begin
        probe_idx  = DATA_W'({key_set, 1'b0});
        single_hit = 1'b1;
        hit_data   = way_data[0];
      end
      2'b10: begin
        probe_idx  = DATA_W'({key_set, 1'b1});
        single_hit = 1'b1;
        hit_data   = way_data[1];
      end
      2'b11: begin
        probe_idx[ERR_BIT] = 1'b1;
        probe_idx[0]       = 1'b1;
      end
      default: probe_idx[ERR_BIT] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pda_q <= '0;
      pdb_q <= '0;
      idx_q <= '0;
    end else begin
      if (acc && (reg_addr == RSEL_PDA)) pda_q <= reg_wdata;
      if (acc && (reg_addr == RSEL_PDB)) pdb_q <= reg_wdata;
      if (acc && (reg_addr == RSEL_IDX)) idx_q <= reg_wdata;
      if (in_fin && (op == OP_PROBE)) begin
        idx_q <= probe_idx;
        if (single_hit) pdb_q <= hit_data;
      end
    end
  end

  always_comb begin
    case (reg_rd_addr)
      RSEL_PDA: reg_rdata = pda_q;
      RSEL_PDB: reg_rdata = pdb_q;
      RSEL_IDX: reg_rdata = idx_q;
      default:  reg_rdata = '0;
    endcase
    reg_wr_ready = ready;
    cmd_done     = done;
    utlb_flush   = flush;
  end
endmodule

// File: rtl/jtlb_cmd_unit_chk.sv
`timescale 1ns/1ps
module jtlb_cmd_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_valid,
  input logic        reg_wr_ready,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        cmd_done,
  input logic        utlb_flush,
  input logic [31:0] idx_q,
  input logic [31:0] pdb_q
);
  logic take, take_cmd, known;

  always_comb begin
    take     = reg_wr_valid && reg_wr_ready;
    take_cmd = take && (reg_addr == 2'd3);
    known    = (reg_wdata >= 32'd1) && (reg_wdata <= 32'd4);
  end

  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && known |=> !reg_wr_ready); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && known |-> ##3 cmd_done); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done); // R3
  AST_WRITE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && (reg_wdata == 32'd2) |-> ##3 utlb_flush); // R8
  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_flush |-> cmd_done); // R8
  AST_KEEP_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && (reg_wdata == 32'd3) |-> ##3 !utlb_flush); // R9
  AST_UINV_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && (reg_wdata == 32'd4) |-> ##3 utlb_flush); // R11
  AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmd && !known |=> reg_wr_ready); // R12
  AST_INDEX_MOVES_LEGALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> cmd_done || $past(take && (reg_addr == 2'd2))); // R4
  AST_PDB_MOVES_LEGALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdb_q) |-> cmd_done || $past(take && (reg_addr == 2'd1))); // R13
endmodule

bind jtlb_cmd_unit jtlb_cmd_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_valid (reg_wr_valid),
  .reg_wr_ready (reg_wr_ready),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .cmd_done     (cmd_done),
  .utlb_flush   (utlb_flush),
  .idx_q        (idx_q),
  .pdb_q        (pdb_q)
);

// File: tb/sim_jtlb_cmd_unit.sv
`timescale 1ns/1ps
module sim_jtlb_cmd_unit;
  localparam int N  = 16;
  localparam int PS = 13;
  localparam logic [31:0] MISS = 32'h8000_0000;
  localparam logic [31:0] DUP  = 32'h8000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_valid = 1'b0;
  logic        reg_wr_ready;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_rd_addr = 2'd0;
  logic [31:0] reg_rdata;
  logic        cmd_done;
  logic        utlb_flush;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  jtlb_cmd_unit #(.ENTRIES(N), .PAGE_SHIFT(PS)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_ready (reg_wr_ready),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rd_addr  (reg_rd_addr),
    .reg_rdata    (reg_rdata),
    .cmd_done     (cmd_done),
    .utlb_flush   (utlb_flush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pda(input int vpn, input bit g, input bit v, input int asid);
    return (32'(vpn) << PS) | (32'(v) << 9) | (32'(g) << 8) | 32'(asid & 8'hff);
  endfunction

  function automatic int vpn_of(input int i);
    return (i >> 1) + 8 * ((i & 1) + 1);
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d, input bit now);
    if (!now) @(negedge clk);
    reg_wr_valid = 1'b1;
    reg_addr     = a;
    reg_wdata    = d;
    while (!reg_wr_ready) @(negedge clk);
    @(posedge clk);
    #1 reg_wr_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    #1 d = reg_rdata;
  endtask

  // returns at the negedge of the completion cycle
  task automatic do_cmd(input int code, input bit now, output logic fl);
    reg_write(2'd3, 32'(code), now);
    @(negedge clk);
    check("R2 ready low while busy", 32'(reg_wr_ready), 32'd0);
    check("R3 no done one cycle after accept", 32'(cmd_done), 32'd0);
    @(negedge clk);
    check("R3 no done two cycles after accept", 32'(cmd_done), 32'd0);
    @(negedge clk);
    check("R3 done pulse", 32'(cmd_done), 32'd1);
    fl = utlb_flush;
  endtask

  task automatic probe(input int vpn, input int asid, output logic [31:0] ix, output logic [31:0] pb);
    logic fl;
    reg_write(2'd0, mk_pda(vpn, 1'b0, 1'b0, asid), 1'b0);
    do_cmd(1, 1'b0, fl);
    check("R11 probe raises no flush", 32'(fl), 32'd0);
    reg_read(2'd2, ix);
    reg_read(2'd1, pb);
  endtask

  task automatic store(input int idx, input logic [31:0] a, input logic [31:0] b, input int code);
    logic fl;
    reg_write(2'd0, a, 1'b0);
    reg_write(2'd1, b, 1'b0);
    reg_write(2'd2, 32'(idx), 1'b0);
    do_cmd(code, 1'b0, fl);
    if (code == 2) check("R8 write flushes", 32'(fl), 32'd1);
    else           check("R9 write-keep does not flush", 32'(fl), 32'd0);
  endtask

  initial begin
    logic [31:0] ix, pb, rv, prev_pb;
    logic fl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rv);
      check("R1 register reset value", rv, 32'd0);
    end
    check("R1 ready after reset", 32'(reg_wr_ready), 32'd1);
    check("R1 done low after reset", 32'(cmd_done), 32'd0);
    check("R1 flush low after reset", 32'(utlb_flush), 32'd0);
    for (int i = 0; i < N; i++) begin
      probe(vpn_of(i), i + 16, ix, pb);
      check("R1 empty buffer misses", ix, MISS);
    end

    // R2 readback and cmd reads zero
    reg_write(2'd0, 32'h1234_5678, 1'b0);
    reg_write(2'd3, 32'd9, 1'b0);
    reg_read(2'd0, rv);
    check("R2 descriptor A readback", rv, 32'h1234_5678);
    reg_read(2'd3, rv);
    check("R2 command reads zero", rv, 32'd0);

    // R8 / R9 fill every entry, alternating write and write-keep
    for (int i = 0; i < N; i++)
      store(i, mk_pda(vpn_of(i), (i % 4) == 3, 1'b1, i + 16),
            32'hA000_0000 | 32'(i), (i % 2 == 0) ? 2 : 3);

    // R4 / R13 / R7 / R5 probe sweep
    for (int i = 0; i < N; i++) begin
      probe(vpn_of(i), i + 16, ix, pb);
      check("R4 hit index", ix, 32'(i));
      check("R13 hit loads descriptor B", pb, 32'hA000_0000 | 32'(i));
      reg_read(2'd0, rv);
      check("R13 probe keeps descriptor A", rv, mk_pda(vpn_of(i), 1'b0, 1'b0, i + 16));
      probe(vpn_of(i), (i + 16) ^ 8'h80, ix, pb);
      if ((i % 4) == 3) check("R7 global matches any tag", ix, 32'(i));
      else begin
        check("R7 tag mismatch misses", ix, MISS);
        check("R13 miss keeps descriptor B", pb, 32'hA000_0000 | 32'(i));
      end
      probe((i >> 1) + 40, 8'h33, ix, pb);
      check("R5 absent page misses", ix, MISS);
    end

    // R6 duplicate in set 2
    store(5, mk_pda(10, 1'b0, 1'b1, 20), 32'hB000_0005, 3);
    reg_read(2'd1, prev_pb);
    probe(10, 20, ix, pb);
    check("R6 duplicate flag", ix, DUP);
    check("R13 duplicate keeps descriptor B", pb, prev_pb);

    // R10 erase
    store(5, 32'd0, 32'd0, 2);
    probe(10, 20, ix, pb);
    check("R10 erased way no longer matches", ix, 32'd4);
    store(0, 32'd0, 32'd0, 2);
    probe(8, 16, ix, pb);
    check("R10 erased entry misses", ix, MISS);
    probe(0, 0, ix, pb);
    check("R10 zero descriptor never matches", ix, MISS);

    // R11 micro-flush with the error flag set
    do_cmd(4, 1'b0, fl);
    check("R11 micro-flush pulses", 32'(fl), 32'd1);
    reg_read(2'd2, rv);
    check("R11 index unchanged", rv, MISS);
    probe(vpn_of(2), 18, ix, pb);
    check("R11 entries untouched", ix, 32'd2);

    // back-to-back: micro-flush accepted in the probe's done cycle
    probe(vpn_of(6), 22, ix, pb);
    check("R4 probe before overlap", ix, 32'd6);
    do_cmd(4, 1'b1, fl);
    check("R11 overlapped micro-flush pulses", 32'(fl), 32'd1);
    reg_read(2'd2, rv);
    check("R11 overlapped index kept", rv, 32'd6);

    // R2 held write during a running probe
    reg_write(2'd0, mk_pda(vpn_of(7), 1'b0, 1'b0, 23), 1'b0);
    reg_write(2'd3, 32'd1, 1'b0);
    reg_write(2'd0, 32'hCAFE_0000, 1'b0);
    reg_read(2'd2, rv);
    check("R2 held write did not disturb probe", rv, 32'd7);
    reg_read(2'd0, rv);
    check("R2 held write lands afterwards", rv, 32'hCAFE_0000);

    // R12 unknown codes
    reg_write(2'd3, 32'd7, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12 unknown code no done", 32'(cmd_done), 32'd0);
      check("R12 unknown code stays ready", 32'(reg_wr_ready), 32'd1);
    end
    reg_write(2'd3, 32'h0000_0101, 1'b0);
    repeat (4) @(negedge clk);
    check("R12 high bits make code unknown", 32'(cmd_done), 32'd0);
    reg_read(2'd2, rv);
    check("R12 index unchanged", rv, 32'd7);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule